// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block is one streaming stage of a framebuffer scan-out path in which the
colour depth can change from one pixel to the next. Each pixel arrives as three
plane values presented together under one valid signal: an 8-bit colour index,
a 32-bit word from the true-colour plane, and a 32-bit word from the control
plane. The top byte of the control word is a mode tag. When the tag equals
0x03, the pixel is shown in direct colour taken from the low 24 bits of the
true-colour word. Any other tag makes the pixel indexed. The index then goes
out on an external palette lookup port, and the entry that comes back is the
pixel colour.

The palette returns data a fixed `LUT_LAT` cycles after the address. The block
carries each pixel's metadata through a matching delay line, so direct and
indexed pixels leave in the order they came in. A small output queue absorbs
backpressure. Input acceptance is governed by a count of pixels held anywhere
inside the block, so a stalled consumer never causes a pixel to be lost or
duplicated. Scan lines have a fixed length of 1024 pixels, and the last pixel
of each line is flagged on the output.

Top module: `pix_mode_sel`

## Requirements
- R1: A pixel is direct when bits 31:24 of its control word equal 0x03 and indexed for every other value of those bits. Bits 23:0 of the control word have no effect. `out_direct` is 1 for a direct pixel and 0 for an indexed one.
- R2: For a direct pixel, `out_rgb` equals bits 23:0 of the true-colour word. Bits 23:16 form the first component (`out_rgb[23:16]`), bits 15:8 the second and bits 7:0 the third. Bits 31:24 of the word and the index byte have no effect on the output.
- R3: In the cycle a pixel is accepted, `lut_addr` equals its index byte. For an indexed pixel, `out_rgb` equals the value on `lut_rgb` exactly `LUT_LAT` cycles later (the palette's red, green and blue in bits 23:16, 15:8 and 7:0). The true-colour word has no effect on an indexed pixel.
- R4: Every accepted pixel appears on the output exactly once, in acceptance order, whatever the mix of modes.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, and `out_rgb`, `out_direct` and `out_eol` are unchanged.
- R6: `out_eol` is 1 on the 1024th, 2048th, ... pixel counted since reset and is 0 on all others.
- R7: During reset `out_valid` is 0, `in_ready` is 1 and the pixel count of R6 restarts from zero.
- R8: The block holds at most `LUT_LAT`+2 pixels. `in_ready` is 0 exactly when that many are held. With `out_ready` held at 1, one pixel is accepted every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The three plane values are present |
| in_ready | output | 1 | The block can take a pixel this cycle |
| in_index | input | 8 | Byte from the indexed plane |
| in_word | input | 32 | Word from the true-colour plane |
| in_ctrl | input | 32 | Word from the control plane; the top byte is the mode tag |
| lut_addr | output | 8 | Palette lookup address |
| lut_rgb | input | 24 | Palette entry, returned `LUT_LAT` cycles after its address |
| out_valid | output | 1 | An output pixel is present |
| out_ready | input | 1 | The consumer takes the output pixel |
| out_rgb | output | 24 | Pixel colour, first component in the top byte |
| out_direct | output | 1 | 1 when the pixel used direct colour |
| out_eol | output | 1 | 1 on the last pixel of a scan line |

## Verification
The stimulus table targets tags that differ from 0x03 by a single bit or only in the upper nibble, and control words whose low 24 bits are nonzero. A decoder that masked the tag or compared the whole word would swap modes, and R1 or R2/R3 would report it. Direct pixels are given nonzero top bytes and indexed pixels distinctive true-colour words, so a mux that leaked the wrong plane shows up as a colour mismatch. Random and fully stalled backpressure, together with a fill to capacity, expose a credit count that is off by one. Such a count either drops the palette result that arrives while the queue is full or throttles a stream that should run every cycle. A run across two line boundaries and a reset in mid-line expose an end-of-line flag that is misplaced by one or not restarted.

// File: rtl/pms_pkg.sv
package pms_pkg;

   localparam int unsigned COMP_W = 8;
   localparam int unsigned RGB_W  = 3 * COMP_W;

   typedef logic [RGB_W-1:0] rgb_t;

   // Metadata that travels alongside a pending palette lookup
   typedef struct packed {
      logic direct;
      logic eol;
      rgb_t rgb;
   } pix_meta_t;

   localparam int unsigned META_W = $bits(pix_meta_t);

endpackage

// File: rtl/pms_decode.sv
module pms_decode #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned TAG_W  = 8,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned RGB_W  = 24,
   parameter logic [TAG_W-1:0] TAG_DIRECT = 8'h03
) (
   input  logic [WORD_W-1:0] ctrl_word,
   input  logic [WORD_W-1:0] colour_word,
   input  logic [IDX_W-1:0]  index_byte,
   output logic              is_direct,
   output logic [RGB_W-1:0]  direct_rgb,
   output logic [IDX_W-1:0]  pal_index
);
   localparam int unsigned TAG_LSB = WORD_W - TAG_W;

   logic [TAG_W-1:0] tag;
   logic             unused_bits;

   assign tag         = ctrl_word[WORD_W-1:TAG_LSB];
   assign is_direct   = (tag == TAG_DIRECT);
   assign direct_rgb  = colour_word[RGB_W-1:0];
   assign pal_index   = index_byte;
   assign unused_bits = ^{ctrl_word[TAG_LSB-1:0], colour_word[WORD_W-1:RGB_W]};

endmodule

// File: rtl/pms_delay.sv
module pms_delay #(
   parameter int unsigned LAT = 2,
   parameter int unsigned W   = 26
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_vld,
   input  logic [W-1:0] d_dat,
   output logic         q_vld,
   output logic [W-1:0] q_dat
);
   generate
      if (LAT == 0) begin : g_wire
         assign q_vld = d_vld;
         assign q_dat = d_dat;
      end else begin : g_pipe
         logic [LAT-1:0] vld_q;
         logic [W-1:0]   dat_q [LAT];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
            end else begin
               vld_q[0] <= d_vld;
               for (int k = 1; k < LAT; k++) vld_q[k] <= vld_q[k-1];
            end
         end

         always_ff @(posedge clk) begin
            dat_q[0] <= d_dat;
            for (int k = 1; k < LAT; k++) dat_q[k] <= dat_q[k-1];
         end

         assign q_vld = vld_q[LAT-1];
         assign q_dat = dat_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/pms_line_cnt.sv
module pms_line_cnt #(
   parameter int unsigned LINE_LEN = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic last
);
   localparam int unsigned CW = (LINE_LEN > 2) ? $clog2(LINE_LEN) : 1;
   localparam logic [CW-1:0] LAST_POS = CW'(LINE_LEN - 1);

   logic [CW-1:0] pos_q;

   assign last = (pos_q == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos_q <= '0;
      else if (step) pos_q <= last ? '0 : pos_q + 1'b1;
   end

endmodule

// File: rtl/pms_fifo.sv
module pms_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 26
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_dat,
   input  logic         pop,
   output logic         empty,
   output logic [W-1:0] head
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_MAX) ? '0 : p + 1'b1;
   endfunction

   assign empty = (cnt_q == '0);
   assign head  = mem[rd_q];

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_dat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= bump(wr_q);
         if (pop)  rd_q <= bump(rd_q);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/pix_mode_sel.sv
module pix_mode_sel #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned TAG_W    = 8,
   parameter int unsigned IDX_W    = 8,
   parameter logic [7:0]  TAG_DIRECT = 8'h03,
   parameter int unsigned LUT_LAT  = 2,
   parameter int unsigned LINE_LEN = 1024
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [IDX_W-1:0]          in_index,
   input  logic [WORD_W-1:0]         in_word,
   input  logic [WORD_W-1:0]         in_ctrl,
   output logic [IDX_W-1:0]          lut_addr,
   input  logic [pms_pkg::RGB_W-1:0] lut_rgb,
   input  logic                      out_ready,
   output logic                      out_valid,
   output logic [pms_pkg::RGB_W-1:0] out_rgb,
   output logic                      out_direct,
   output logic                      out_eol
);
   import pms_pkg::*;

   localparam int unsigned DEPTH = LUT_LAT + 2;
   localparam int unsigned OCC_W = $clog2(DEPTH + 1);
   localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

   generate
      if (WORD_W < RGB_W + TAG_W) begin : g_bad_word
         $error("WORD_W must hold the colour and the tag");
      end
      if (TAG_W != 8) begin : g_bad_tag
         $error("TAG_W must be 8");
      end
      if (LINE_LEN < 2) begin : g_bad_line
         $error("LINE_LEN must be at least 2");
      end
      if (LUT_LAT > 8) begin : g_bad_lat
         $error("LUT_LAT above 8 is not supported");
      end
   endgenerate

   logic      acc, pop;
   logic      dec_direct;
   rgb_t      dec_rgb;
   logic      line_last;
   pix_meta_t meta_in, meta_out, fifo_in, fifo_head;
   logic      meta_vld;
   logic      fifo_empty;
   logic [OCC_W-1:0] occ_q;

   assign in_ready = (occ_q < OCC_MAX);
   assign acc      = in_valid & in_ready;
   assign pop      = out_valid & out_ready;

   pms_decode #(
      .WORD_W(WORD_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .RGB_W(RGB_W),
      .TAG_DIRECT(TAG_DIRECT)
   ) u_dec (
      .ctrl_word  (in_ctrl),
      .colour_word(in_word),
      .index_byte (in_index),
      .is_direct  (dec_direct),
      .direct_rgb (dec_rgb),
      .pal_index  (lut_addr)
   );

   pms_line_cnt #(.LINE_LEN(LINE_LEN)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .step (acc),
      .last (line_last)
   );

   always_comb begin
      meta_in.direct = dec_direct;
      meta_in.eol    = line_last;
      meta_in.rgb    = dec_rgb;
   end

   pms_delay #(.LAT(LUT_LAT), .W(META_W)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .d_vld(acc),
      .d_dat(meta_in),
      .q_vld(meta_vld),
      .q_dat(meta_out)
   );

   // Merge point: the palette entry lines up with the delayed metadata
   always_comb begin
      fifo_in     = meta_out;
      fifo_in.rgb = meta_out.direct ? meta_out.rgb : lut_rgb;
   end

   pms_fifo #(.DEPTH(DEPTH), .W(META_W)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (meta_vld),
      .push_dat(fifo_in),
      .pop     (pop),
      .empty   (fifo_empty),
      .head    (fifo_head)
   );

   assign out_valid  = ~fifo_empty;
   assign out_rgb    = fifo_head.rgb;
   assign out_direct = fifo_head.direct;
   assign out_eol    = fifo_head.eol;

   // Credit count: pixels in the delay line plus pixels in the queue
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= '0;
      end else begin
         case ({acc, pop})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

endmodule

// File: rtl/pms_chk.sv
module pms_chk #(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned LUT_LAT  = 2,
   parameter int unsigned LINE_LEN = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [IDX_W-1:0]  in_index,
   input logic [IDX_W-1:0]  lut_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [23:0]       out_rgb,
   input logic              out_direct,
   input logic              out_eol
);
   localparam int unsigned CAP   = LUT_LAT + 2;
   localparam int unsigned OW    = $clog2(CAP + 1);
   localparam int unsigned PW    = (LINE_LEN > 2) ? $clog2(LINE_LEN) : 1;
   localparam logic [PW-1:0] LASTP = PW'(LINE_LEN - 1);

   logic [OW-1:0] held_q;
   logic [PW-1:0] opos_q;
   logic          a_in, a_out;

   assign a_in  = in_valid & in_ready;
   assign a_out = out_valid & out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         opos_q <= '0;
      end else begin
         held_q <= held_q + OW'(a_in) - OW'(a_out);
         if (a_out) opos_q <= (opos_q == LASTP) ? '0 : opos_q + 1'b1;
      end
   end

   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_rgb)
                                  && $stable(out_direct) && $stable(out_eol));
   // R8
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held_q == OW'(CAP) |-> !in_ready);
   // R8
   room_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held_q < OW'(CAP) |-> in_ready);
   // R4
   no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> held_q != '0);
   // R6
   eol_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_eol == (opos_q == LASTP)));
   // R3
   lut_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |-> lut_addr == in_index);
   // R7
   rst_clear_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid && in_ready);

   logic unused_w;
   assign unused_w = ^{out_rgb, out_direct, 1'(WORD_W)};

endmodule

bind pix_mode_sel pms_chk #(
   .IDX_W(IDX_W), .WORD_W(WORD_W), .LUT_LAT(LUT_LAT), .LINE_LEN(LINE_LEN)
) u_pms_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_index(in_index), .lut_addr(lut_addr), .out_valid(out_valid),
   .out_ready(out_ready), .out_rgb(out_rgb), .out_direct(out_direct),
   .out_eol(out_eol)
);

// File: tb/test_pix_mode_sel.sv
module test_pix_mode_sel;
   localparam int LAT  = 2;
   localparam int CAP  = LAT + 2;
   localparam int LINE = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_index = '0;
   logic [31:0] in_word = '0;
   logic [31:0] in_ctrl = '0;
   logic [7:0]  lut_addr;
   logic [23:0] lut_rgb;
   logic        out_ready = 1'b1;
   logic        out_valid;
   logic [23:0] out_rgb;
   logic        out_direct;
   logic        out_eol;

   int compared = 0;
   int mismatched = 0;

   always #4 clk = ~clk;

   pix_mode_sel #(.LUT_LAT(LAT), .LINE_LEN(LINE)) i_pix_mode_sel (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_index(in_index), .in_word(in_word), .in_ctrl(in_ctrl),
      .lut_addr(lut_addr), .lut_rgb(lut_rgb), .out_ready(out_ready),
      .out_valid(out_valid), .out_rgb(out_rgb), .out_direct(out_direct),
      .out_eol(out_eol)
   );

   // Palette model with a fixed latency of LAT cycles
   function automatic logic [23:0] pal(input logic [7:0] i);
      return {8'(i * 8'd3), i ^ 8'h3C, ~i};
   endfunction

   logic [23:0] lq1, lq2;
   always @(posedge clk) begin
      lq1 <= pal(lut_addr);
      lq2 <= lq1;
   end
   assign lut_rgb = lq2;

   // {index, true-colour word, control word}
   localparam logic [71:0] VEC [12] = '{
      {8'h11, 32'hFF123456, 32'h03000000},
      {8'h22, 32'h00ABCDEF, 32'h02FFFFFF},
      {8'h33, 32'hDEADBEEF, 32'h04000000},
      {8'h44, 32'h00000000, 32'h03FFFFFF},
      {8'hFF, 32'h00FFFFFF, 32'h03000001},
      {8'h00, 32'h12345678, 32'h00000000},
      {8'hFF, 32'h11111111, 32'hFF000000},
      {8'h80, 32'h00800001, 32'h83000000},
      {8'h7E, 32'hAB0000FF, 32'h13000000},
      {8'h01, 32'h01020304, 32'h03123456},
      {8'hC3, 32'h5A5AA5A5, 32'h30000000},
      {8'h5A, 32'h00C0FFEE, 32'h03ABCDEF}
   };

   // Scoreboard
   logic [23:0] sb_rgb [64];
   logic        sb_dir [64];
   logic        sb_eol [64];
   int wr = 0, rd = 0, pix_n = 0, eol_seen = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Monitor: samples 3 ns after the falling edge
   logic        p_stall = 1'b0;
   logic [25:0] p_val;
   always begin
      @(negedge clk);
      #3;
      if (rst_n) begin
         if (p_stall) begin
            chk(out_valid && {out_direct, out_eol, out_rgb} == p_val, "R5",
                "held output", {5'd0, out_valid, out_direct, out_eol, out_rgb},
                {6'd1, p_val});
         end
         p_stall = out_valid && !out_ready;
         p_val   = {out_direct, out_eol, out_rgb};
         if (in_valid && in_ready) begin
            logic d;
            d = (in_ctrl[31:24] == 8'h03);
            sb_dir[wr % 64] = d;
            sb_rgb[wr % 64] = d ? in_word[23:0] : pal(in_index);
            sb_eol[wr % 64] = ((pix_n % LINE) == LINE - 1);
            wr++;
            pix_n++;
         end
         if (out_valid && out_ready) begin
            if (rd == wr) begin
               chk(0, "R4", "output with nothing pending", 1, 0);
            end else begin
               chk(out_rgb == sb_rgb[rd % 64], sb_dir[rd % 64] ? "R2" : "R3",
                   "rgb", {8'd0, out_rgb}, {8'd0, sb_rgb[rd % 64]});
               chk(out_direct == sb_dir[rd % 64], "R1", "direct flag",
                   {31'd0, out_direct}, {31'd0, sb_dir[rd % 64]});
               chk(out_eol == sb_eol[rd % 64], "R6", "eol flag",
                   {31'd0, out_eol}, {31'd0, sb_eol[rd % 64]});
               if (out_eol) eol_seen++;
               rd++;
            end
         end
      end else begin
         p_stall = 1'b0;
      end
   end

   // Output readiness pattern: 0 always ready, 1 never, 2 pseudo-random
   int mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
         0: out_ready = 1'b1;
         1: out_ready = 1'b0;
         default: out_ready = lfsr[0] | lfsr[3];
      endcase
   end

   // Called at a falling edge; returns at the falling edge after acceptance
   task automatic send(input logic [71:0] v);
      bit taken;
      in_valid = 1'b1;
      {in_index, in_word, in_ctrl} = v;
      taken = 0;
      while (!taken) begin
         #3;
         taken = in_ready;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while (rd != wr && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      mismatched++;
      $display("FAIL R4 watchdog expired actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int acc_n, low_n, eol_base;
      // R7: reset state
      repeat (3) @(negedge clk);
      #3;
      chk(!out_valid && in_ready, "R7", "reset state",
          {30'd0, out_valid, in_ready}, 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: table, consumer always ready
      mode = 0;
      for (int i = 0; i < 12; i++) send(VEC[i]);
      // R5 R4: table again under random backpressure
      mode = 2;
      for (int r = 0; r < 4; r++)
         for (int i = 0; i < 12; i++) send(VEC[(i + r) % 12]);
      drain();

      // R8: fill with the consumer stalled
      mode = 1;
      @(negedge clk);
      in_valid = 1'b1;
      {in_index, in_word, in_ctrl} = VEC[2];
      acc_n = 0;
      for (int c = 0; c < 12; c++) begin
         #3;
         if (in_ready) acc_n++;
         @(negedge clk);
      end
      #3;
      chk(acc_n == CAP, "R8", "pixels taken while stalled", acc_n, CAP);
      chk(!in_ready, "R8", "in_ready when full", {31'd0, in_ready}, 0);
      @(negedge clk);
      in_valid = 1'b0;
      mode = 0;
      drain();

      // R8: back-to-back throughput with the consumer always ready
      @(negedge clk);
      in_valid = 1'b1;
      low_n = 0;
      for (int c = 0; c < 40; c++) begin
         {in_index, in_word, in_ctrl} = VEC[c % 12];
         #3;
         if (!in_ready) low_n++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      chk(low_n == 0, "R8", "stall cycles at full rate", low_n, 0);
      drain();

      // R6: cross at least two line boundaries under random backpressure
      mode = 2;
      eol_base = eol_seen;
      while (pix_n < 2 * LINE + 5) send(VEC[pix_n % 12]);
      mode = 0;
      drain();
      chk(eol_seen - eol_base == 2, "R6", "line ends seen",
          eol_seen - eol_base, 2);

      // R7: reset in mid-line with pixels held inside
      mode = 1;
      for (int i = 0; i < 3; i++) send(VEC[i]);
      rst_n = 1'b0;
      wr = 0; rd = 0; pix_n = 0;
      #3;
      chk(!out_valid && in_ready, "R7", "state after mid-line reset",
          {30'd0, out_valid, in_ready}, 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      mode = 0;
      @(negedge clk);
      eol_base = eol_seen;
      for (int i = 0; i < LINE; i++) send(VEC[i % 12]);
      drain();
      chk(eol_seen - eol_base == 1, "R7", "line count restarted",
          eol_seen - eol_base, 1);

      // R4: everything accepted came out
      chk(rd == wr && !out_valid, "R4", "pending after drain", wr - rd, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule